// File: doc/BRIEF.md
# Channel Completion Report and Residue Tracker

This block follows one transfer channel from descriptor to descriptor. It takes the next descriptor (a byte length and a flags word) from the descriptor ring. It keeps a residue counter of the bytes still to move in that descriptor, and it lowers the counter by the size of each data beat the channel accepts. The memory side and the peripheral data path lie outside the block. The block sees only the accepted beats and the size of each one.

When the residue reaches zero, the block writes a completion report into a small ring of report slots. A report holds the running byte total of the channel as a low word and a high word, then the length of the descriptor, then its flags. Software drains the ring through a single read port, one word per read. The ring exposes a status word that gives its slot pointers, its empty and full conditions, and a sticky overflow error. A per-channel interrupt status register holds a descriptor-done cause and an error cause. Software clears each cause by writing one to it. A mask register enables the causes onto the interrupt line.

The control sequencer has three states. `ST_IDLE` holds no descriptor. `ST_RUN` counts beats down. `ST_DONE` lasts one cycle and pushes the report. The transitions are:
- load: `ST_IDLE` goes to `ST_RUN` when a descriptor with a nonzero length is accepted.
- load-empty: `ST_IDLE` goes to `ST_DONE` when a descriptor of length zero is accepted.
- drain: `ST_RUN` goes to `ST_DONE` when a beat uses up the residue.
- chain: `ST_DONE` goes to `ST_RUN`, or to `ST_DONE` for a zero length, when the next descriptor is accepted in the same cycle as the report push.
- rest: `ST_DONE` goes to `ST_IDLE` when no descriptor is offered.

The report reader has its own state machine. It steps through the four word positions `WD_CNT_LO`, `WD_CNT_HI`, `WD_LEN` and `WD_FLAGS`, and it retires the slot after `WD_FLAGS`.

Top module: `cmpl_trk`

## Requirements
- R1: After reset the residue is 0, the ring status reads 0x100 (empty only), interrupt status and mask are 0, irq is low, desc_ready is high and beat_ready is low.
- R2: When a descriptor is accepted (desc_valid and desc_ready), the residue equals its length on the next cycle. This includes acceptance during the report cycle, so the residue can rise between two reads.
- R3: Each accepted beat (beat_valid while beat_ready) lowers the residue by min(beat_bytes, residue). The same amount is added to the running total. beat_ready is high only while a descriptor is being counted, and beats offered at other times change nothing.
- R4: A completed descriptor pushes one report. Its four words are read from rpt_data in this order: running total bits 31:0, running total bits 63:32, descriptor length, descriptor flags. Each rpt_rd pulse advances one word, and the slot is freed after the fourth word.
- R5: rpt_status has the write slot in bits 1:0, the read slot in bits 5:4, empty in bit 8, full in bit 9 and the overflow error in bit 10. All other bits are 0.
- R6: A report that completes while all slots are occupied is dropped. Status bit 10 is then set and stays set until a rpt_err_clr pulse, and a new overflow in the same cycle wins over the clear.
- R7: Interrupt status bit 0 (done) is set when the finished descriptor has flags bit 16 set. The report is pushed whether or not that bit is set.
- R8: Interrupt status bit 6 (error) is set by a desc_ring_err pulse or by a report-ring overflow.
- R9: A sts_wr_en write clears each status bit whose data bit is one. A cause that sets in the same cycle wins over the clear.
- R10: The mask stores only bits 0 and 6, and the other bits read 0. irq is the OR of status AND mask.
- R11: rpt_rd while the ring is empty returns 0 on rpt_data and changes neither the pointers nor the word position.
- R12: A descriptor of length zero completes at once and pushes a report with length 0 and an unchanged total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Next descriptor offered |
| desc_len | input | 32 | Byte length of offered descriptor |
| desc_flags | input | 32 | Flags of offered descriptor (bit 16 requests notification) |
| desc_ready | output | 1 | Tracker can take a descriptor this cycle |
| desc_ring_err | input | 1 | Pulse: descriptor ring error |
| beat_valid | input | 1 | A data beat is offered |
| beat_bytes | input | BEAT_W | Bytes moved by the beat |
| beat_ready | output | 1 | Beats are being counted |
| residue | output | 32 | Bytes left in current descriptor |
| rpt_rd | input | 1 | Pulse: consume one report word |
| rpt_data | output | 32 | Report word at the read position |
| rpt_status | output | 32 | Report ring status word |
| rpt_err_clr | input | 1 | Pulse: clear ring overflow error |
| sts_wr_en | input | 1 | Write-one-to-clear strobe for interrupt status |
| sts_wr_data | input | 32 | Bits to clear |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_data | input | 32 | New mask value |
| int_status | output | 32 | Interrupt status (bits 0 and 6) |
| int_mask | output | 32 | Interrupt mask (bits 0 and 6) |
| irq | output | 1 | Channel interrupt |

## Verification
The bench builds the block with its defaults: four report slots and an 8-bit beat size field. With only four slots, a burst of five short descriptors without reads is enough to reach the overflow drop. The pointer wrap and the full/empty distinction come within reach after a few descriptors. Because the beat size field is narrow, a beat can be larger than the remaining residue, which tests the clamping. Descriptors can also be chained so that a new one arrives in the report cycle, which shows the residue rising.

// File: rtl/cmpl_trk_pkg.sv
package cmpl_trk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } trk_state_e;

    typedef enum logic [1:0] {
        WD_CNT_LO,
        WD_CNT_HI,
        WD_LEN,
        WD_FLAGS
    } rpt_word_e;

    localparam int WORD_W     = 32;
    localparam int TOTAL_W    = 2 * WORD_W;

    // ring status word positions
    localparam int RS_WR_LSB  = 0;
    localparam int RS_RD_LSB  = 4;
    localparam int RS_EMPTY   = 8;
    localparam int RS_FULL    = 9;
    localparam int RS_ERR     = 10;

    // interrupt cause positions and notify flag
    localparam int IS_DONE    = 0;
    localparam int IS_ERR     = 6;
    localparam int NOTIFY_BIT = 16;

    typedef struct packed {
        logic [TOTAL_W-1:0] total;
        logic [WORD_W-1:0]  len;
        logic [WORD_W-1:0]  flags;
    } rpt_entry_t;

endpackage

// File: rtl/cmpl_trk_fsm.sv
module cmpl_trk_fsm
    import cmpl_trk_pkg::*;
#(
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    input  logic [WORD_W-1:0] desc_len,
    input  logic [WORD_W-1:0] desc_flags,
    output logic              desc_ready,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic              beat_ready,
    output logic [WORD_W-1:0] residue,
    output logic              push,
    output rpt_entry_t        push_entry
);

    trk_state_e state_q, state_d;

    logic [WORD_W-1:0]  resid_q;
    logic [WORD_W-1:0]  len_q;
    logic [WORD_W-1:0]  flags_q;
    logic [TOTAL_W-1:0] total_q;

    logic [WORD_W-1:0]  beat_ext;
    logic [WORD_W-1:0]  take;
    logic               last_beat;
    logic               load;
    logic               count;

    assign beat_ext  = WORD_W'(beat_bytes);
    assign last_beat = (beat_ext >= resid_q);
    assign take      = last_beat ? resid_q : beat_ext;
    assign load      = desc_valid && desc_ready;
    assign count     = beat_valid && beat_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: load, load-empty, drain, chain, rest
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (desc_valid) state_d = (desc_len == '0) ? ST_DONE : ST_RUN;
            end
            ST_RUN: begin
                if (beat_valid && last_beat) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (desc_valid) state_d = (desc_len == '0) ? ST_DONE : ST_RUN;
                else            state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        desc_ready = 1'b0;
        beat_ready = 1'b0;
        push       = 1'b0;
        unique case (state_q)
            ST_IDLE: desc_ready = 1'b1;
            ST_RUN:  beat_ready = 1'b1;
            ST_DONE: begin
                desc_ready = 1'b1;
                push       = 1'b1;
            end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resid_q <= '0;
            len_q   <= '0;
            flags_q <= '0;
            total_q <= '0;
        end else begin
            if (load) begin
                resid_q <= desc_len;
                len_q   <= desc_len;
                flags_q <= desc_flags;
            end else if (count) begin
                resid_q <= resid_q - take;
            end
            if (count) total_q <= total_q + TOTAL_W'(take);
        end
    end

    assign residue          = resid_q;
    assign push_entry.total = total_q;
    assign push_entry.len   = len_q;
    assign push_entry.flags = flags_q;

endmodule

// File: rtl/cmpl_trk_ring.sv
module cmpl_trk_ring
    import cmpl_trk_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  rpt_entry_t        entry,
    input  logic              rd_en,
    input  logic              err_clr,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] status,
    output logic              overflow
);

    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    rpt_entry_t      mem [SLOTS];
    logic [PTR_W:0]  wr_ptr, rd_ptr;
    logic            err_q;
    rpt_word_e       word_q, word_d;

    logic            empty, full, pop, advance;
    rpt_entry_t      head;

    assign empty    = (wr_ptr == rd_ptr);
    assign full     = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) &&
                      (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]);
    assign overflow = push && full;
    assign pop      = rd_en && !empty;
    assign advance  = pop && (word_q == WD_FLAGS);
    assign head     = mem[rd_ptr[PTR_W-1:0]];

    // word position register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= WD_CNT_LO;
        else        word_q <= word_d;
    end

    always_comb begin
        word_d = word_q;
        if (pop) begin
            unique case (word_q)
                WD_CNT_LO: word_d = WD_CNT_HI;
                WD_CNT_HI: word_d = WD_LEN;
                WD_LEN:    word_d = WD_FLAGS;
                WD_FLAGS:  word_d = WD_CNT_LO;
                default:   word_d = WD_CNT_LO;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        if (!empty) begin
            unique case (word_q)
                WD_CNT_LO: rd_data = head.total[WORD_W-1:0];
                WD_CNT_HI: rd_data = head.total[TOTAL_W-1:WORD_W];
                WD_LEN:    rd_data = head.len;
                WD_FLAGS:  rd_data = head.flags;
                default:   rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_ptr[PTR_W-1:0]] <= entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            err_q  <= 1'b0;
        end else begin
            if (push && !full) wr_ptr <= wr_ptr + 1'b1;
            if (advance)       rd_ptr <= rd_ptr + 1'b1;
            if (overflow)      err_q  <= 1'b1;
            else if (err_clr)  err_q  <= 1'b0;
        end
    end

    always_comb begin
        status = '0;
        status[RS_WR_LSB +: PTR_W] = wr_ptr[PTR_W-1:0];
        status[RS_RD_LSB +: PTR_W] = rd_ptr[PTR_W-1:0];
        status[RS_EMPTY]           = empty;
        status[RS_FULL]            = full;
        status[RS_ERR]             = err_q;
    end

endmodule

// File: rtl/cmpl_trk_irq.sv
module cmpl_trk_irq
    import cmpl_trk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_done,
    input  logic              set_err,
    input  logic              sts_wr_en,
    input  logic [WORD_W-1:0] sts_wr_data,
    input  logic              mask_wr_en,
    input  logic [WORD_W-1:0] mask_wr_data,
    output logic [WORD_W-1:0] int_status,
    output logic [WORD_W-1:0] int_mask,
    output logic              irq
);

    logic done_q, err_q, mdone_q, merr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            mdone_q <= 1'b0;
            merr_q  <= 1'b0;
        end else begin
            if (set_done)                              done_q <= 1'b1;
            else if (sts_wr_en && sts_wr_data[IS_DONE]) done_q <= 1'b0;
            if (set_err)                               err_q  <= 1'b1;
            else if (sts_wr_en && sts_wr_data[IS_ERR])  err_q  <= 1'b0;
            if (mask_wr_en) begin
                mdone_q <= mask_wr_data[IS_DONE];
                merr_q  <= mask_wr_data[IS_ERR];
            end
        end
    end

    always_comb begin
        int_status          = '0;
        int_status[IS_DONE] = done_q;
        int_status[IS_ERR]  = err_q;
        int_mask            = '0;
        int_mask[IS_DONE]   = mdone_q;
        int_mask[IS_ERR]    = merr_q;
    end

    assign irq = |(int_status & int_mask);

endmodule

// File: rtl/cmpl_trk.sv
module cmpl_trk
    import cmpl_trk_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    input  logic [31:0]       desc_len,
    input  logic [31:0]       desc_flags,
    output logic              desc_ready,
    input  logic              desc_ring_err,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic              beat_ready,
    output logic [31:0]       residue,
    input  logic              rpt_rd,
    output logic [31:0]       rpt_data,
    output logic [31:0]       rpt_status,
    input  logic              rpt_err_clr,
    input  logic              sts_wr_en,
    input  logic [31:0]       sts_wr_data,
    input  logic              mask_wr_en,
    input  logic [31:0]       mask_wr_data,
    output logic [31:0]       int_status,
    output logic [31:0]       int_mask,
    output logic              irq
);

    logic       push, overflow;
    rpt_entry_t push_entry;

    cmpl_trk_fsm #(.BEAT_W(BEAT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_valid (desc_valid),
        .desc_len   (desc_len),
        .desc_flags (desc_flags),
        .desc_ready (desc_ready),
        .beat_valid (beat_valid),
        .beat_bytes (beat_bytes),
        .beat_ready (beat_ready),
        .residue    (residue),
        .push       (push),
        .push_entry (push_entry)
    );

    cmpl_trk_ring #(.SLOTS(SLOTS)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .entry    (push_entry),
        .rd_en    (rpt_rd),
        .err_clr  (rpt_err_clr),
        .rd_data  (rpt_data),
        .status   (rpt_status),
        .overflow (overflow)
    );

    cmpl_trk_irq u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_done     (push && push_entry.flags[NOTIFY_BIT]),
        .set_err      (overflow || desc_ring_err),
        .sts_wr_en    (sts_wr_en),
        .sts_wr_data  (sts_wr_data),
        .mask_wr_en   (mask_wr_en),
        .mask_wr_data (mask_wr_data),
        .int_status   (int_status),
        .int_mask     (int_mask),
        .irq          (irq)
    );

endmodule

// File: rtl/cmpl_trk_chk.sv
module cmpl_trk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        desc_valid,
    input logic [31:0] desc_len,
    input logic        desc_ready,
    input logic        beat_valid,
    input logic        beat_ready,
    input logic [31:0] residue,
    input logic        rpt_rd,
    input logic [31:0] rpt_status,
    input logic        sts_wr_en,
    input logic [31:0] sts_wr_data,
    input logic [31:0] int_status
);

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ready) |=> (residue == $past(desc_len)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ready && !beat_valid) |=> $stable(residue));

    p_not_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rpt_status[8] && rpt_status[9]));

    p_ovf_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rpt_status[10]) |-> int_status[6]);

    p_done_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_status[0]) |-> $past(sts_wr_en && sts_wr_data[0]));

    p_empty_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_status[8] && rpt_rd) |=> $stable(rpt_status[5:4]));

endmodule

bind cmpl_trk cmpl_trk_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .desc_valid  (desc_valid),
    .desc_len    (desc_len),
    .desc_ready  (desc_ready),
    .beat_valid  (beat_valid),
    .beat_ready  (beat_ready),
    .residue     (residue),
    .rpt_rd      (rpt_rd),
    .rpt_status  (rpt_status),
    .sts_wr_en   (sts_wr_en),
    .sts_wr_data (sts_wr_data),
    .int_status  (int_status)
);

// File: tb/tb_cmpl_trk.sv
module tb_cmpl_trk;

    localparam int SLOTS  = 4;
    localparam int BEAT_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              desc_valid = 1'b0;
    logic [31:0]       desc_len = '0;
    logic [31:0]       desc_flags = '0;
    logic              desc_ready;
    logic              desc_ring_err = 1'b0;
    logic              beat_valid = 1'b0;
    logic [BEAT_W-1:0] beat_bytes = '0;
    logic              beat_ready;
    logic [31:0]       residue;
    logic              rpt_rd = 1'b0;
    logic [31:0]       rpt_data;
    logic [31:0]       rpt_status;
    logic              rpt_err_clr = 1'b0;
    logic              sts_wr_en = 1'b0;
    logic [31:0]       sts_wr_data = '0;
    logic              mask_wr_en = 1'b0;
    logic [31:0]       mask_wr_data = '0;
    logic [31:0]       int_status;
    logic [31:0]       int_mask;
    logic              irq;

    cmpl_trk #(.SLOTS(SLOTS), .BEAT_W(BEAT_W)) dut (.*);

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string ctx = "R1";

    // behavioural reference
    int          m_phase;      // 0 idle, 1 counting, 2 reporting
    longint      m_res;
    longint      m_total;
    logic [31:0] m_len, m_flags;
    logic [31:0] m_q[$];
    int          m_wr, m_rd, m_wi;
    bit          m_rerr, m_done, m_err, m_mdone, m_merr;
    int          ent;
    bit          do_push, ovf;
    longint      b;

    task automatic m_reset();
        m_phase = 0; m_res = 0; m_total = 0; m_len = 0; m_flags = 0;
        m_q.delete(); m_wr = 0; m_rd = 0; m_wi = 0;
        m_rerr = 0; m_done = 0; m_err = 0; m_mdone = 0; m_merr = 0;
    endtask

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            ent     = m_wr - m_rd;
            do_push = (m_phase == 2);
            ovf     = do_push && (ent == SLOTS);
            if (rpt_rd && ent > 0) begin
                if (m_wi == 3) begin
                    repeat (4) void'(m_q.pop_front());
                    m_rd++; m_wi = 0;
                end else m_wi++;
            end
            if (do_push && !ovf) begin
                m_q.push_back(m_total[31:0]);
                m_q.push_back(m_total[63:32]);
                m_q.push_back(m_len);
                m_q.push_back(m_flags);
                m_wr++;
            end
            if (ovf) m_rerr = 1; else if (rpt_err_clr) m_rerr = 0;
            if (sts_wr_en && sts_wr_data[0]) m_done = 0;
            if (sts_wr_en && sts_wr_data[6]) m_err = 0;
            if (do_push && m_flags[16]) m_done = 1;
            if (ovf || desc_ring_err) m_err = 1;
            if (mask_wr_en) begin m_mdone = mask_wr_data[0]; m_merr = mask_wr_data[6]; end
            case (m_phase)
                1: if (beat_valid) begin
                    b = longint'(beat_bytes);
                    if (b >= m_res) begin m_total += m_res; m_res = 0; m_phase = 2; end
                    else begin m_total += b; m_res -= b; end
                end
                default: if (desc_valid) begin
                    m_res = longint'(desc_len); m_len = desc_len; m_flags = desc_flags;
                    m_phase = (desc_len == 0) ? 2 : 1;
                end else m_phase = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", ctx, tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        logic [31:0] s;
        int e;
        e = m_wr - m_rd;
        s = '0;
        s[1:0]  = 2'(m_wr % SLOTS);
        s[5:4]  = 2'(m_rd % SLOTS);
        s[8]    = (e == 0);
        s[9]    = (e == SLOTS);
        s[10]   = m_rerr;
        return s;
    endfunction

    task automatic compare_all();
        logic [31:0] exp_is, exp_im, exp_rd;
        exp_is = '0; exp_is[0] = m_done; exp_is[6] = m_err;
        exp_im = '0; exp_im[0] = m_mdone; exp_im[6] = m_merr;
        exp_rd = (m_wr != m_rd) ? m_q[m_wi] : 32'h0;
        chk("residue R2/R3", residue, 32'(m_res));
        chk("desc_ready R3", {31'b0, desc_ready}, {31'b0, m_phase != 1});
        chk("beat_ready R3", {31'b0, beat_ready}, {31'b0, m_phase == 1});
        chk("rpt_status R5", rpt_status, m_status());
        chk("rpt_data R4", rpt_data, exp_rd);
        chk("int_status R9", int_status, exp_is);
        chk("int_mask R10", int_mask, exp_im);
        chk("irq R10", {31'b0, irq}, {31'b0, |(exp_is & exp_im)});
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) compare_all();
        rpt_rd = 0; sts_wr_en = 0; mask_wr_en = 0; desc_ring_err = 0; rpt_err_clr = 0;
    endtask

    task automatic give_desc(input logic [31:0] len, input logic [31:0] fl);
        desc_valid = 1; desc_len = len; desc_flags = fl;
        while (m_phase == 1) tick();
        tick();
        desc_valid = 0;
    endtask

    task automatic beat(input int n);
        beat_valid = 1; beat_bytes = BEAT_W'(n);
        tick();
        beat_valid = 0;
    endtask

    task automatic rd_word(input logic [31:0] exp, input string tag);
        chk(tag, rpt_data, exp);
        rpt_rd = 1;
        tick();
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R1 reset values
        chk("R1 residue", residue, 0);
        chk("R1 rpt_status", rpt_status, 32'h100);
        chk("R1 int_status", int_status, 0);
        chk("R1 int_mask", int_mask, 0);
        chk("R1 irq/ready", {29'b0, irq, desc_ready, beat_ready}, 32'b010);

        // R10: only bits 0 and 6 stored
        ctx = "R10";
        mask_wr_en = 1; mask_wr_data = 32'hFFFF_FFFF; tick(); tick();
        chk("R10 mask", int_mask, 32'h41);

        // R3: beats while idle are ignored
        ctx = "R3";
        beat(9); beat(3);
        chk("R3 idle residue", residue, 0);

        // R2 R3 R4 R7: length 10, notify, clamp on last beat
        ctx = "R7";
        give_desc(10, 32'h0001_0000);
        chk("R2 residue load", residue, 10);
        beat(4); beat(0); beat(4);
        chk("R3 residue after 8", residue, 2);
        beat(200);
        tick();
        chk("R7 done bit", int_status, 32'h1);
        chk("R7 irq", {31'b0, irq}, 32'h1);
        ctx = "R4";
        rd_word(10, "R4 total lo");
        rd_word(0, "R4 total hi");
        rd_word(10, "R4 len");
        rd_word(32'h0001_0000, "R4 flags");
        chk("R4 ring empty", rpt_status, 32'h111);

        // R9: W1C clear
        ctx = "R9";
        sts_wr_en = 1; sts_wr_data = 32'h1; tick(); tick();
        chk("R9 cleared", int_status, 0);

        // R12: zero length, no notify
        ctx = "R12";
        give_desc(0, 32'h5);
        tick();
        chk("R12 no done", int_status, 0);
        rd_word(10, "R12 total lo");
        rd_word(0, "R12 total hi");
        rd_word(0, "R12 len");
        rd_word(32'h5, "R12 flags");

        // R2: chained descriptor loaded in the report cycle, residue rises
        ctx = "R2";
        give_desc(6, 0);
        desc_valid = 1; desc_len = 20; desc_flags = 32'h0001_0000;
        beat(6);
        chk("R2 report cycle residue", residue, 0);
        tick();
        desc_valid = 0;
        chk("R2 risen residue", residue, 20);
        beat(7); beat(7); beat(7);
        tick();

        // drain two reports
        repeat (8) begin rpt_rd = 1; tick(); end

        // R6 R8: overflow with five short reports
        ctx = "R6";
        for (int i = 0; i < 5; i++) begin
            give_desc(1, 32'h0);
            beat(1);
        end
        tick(); tick();
        chk("R6 full+err", rpt_status & 32'h700, 32'h600);
        chk("R8 err cause", int_status[6] ? 32'h1 : 32'h0, 32'h1);

        // R9: set wins over clear
        ctx = "R9";
        sts_wr_en = 1; sts_wr_data = 32'h41; desc_ring_err = 1; tick(); tick();
        chk("R9 set wins", int_status, 32'h40);
        sts_wr_en = 1; sts_wr_data = 32'h40; tick(); tick();
        chk("R9 err cleared", int_status, 0);

        ctx = "R6";
        rpt_err_clr = 1; tick(); tick();
        chk("R6 err cleared", rpt_status[10] ? 32'h1 : 32'h0, 0);

        // R8: descriptor ring error alone
        ctx = "R8";
        desc_ring_err = 1; tick(); tick();
        chk("R8 desc err", int_status, 32'h40);

        // R11: drain then read when empty
        ctx = "R11";
        repeat (16) begin rpt_rd = 1; tick(); end
        chk("R11 empty", rpt_status[8] ? 32'h1 : 32'h0, 32'h1);
        rd_word(0, "R11 empty data");
        rd_word(0, "R11 empty data again");
        give_desc(3, 0); beat(3); tick(); tick();
        rd_word(32'(m_total), "R11 position kept");

        repeat (4) tick();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule